// File: doc/BRIEF.md
# Internal RAM Stack and Call Unit

This block owns the 8-bit stack pointer of a small 8-bit core and the byte-wide stack that lives in the core's on-chip data RAM. The stack grows upward. A push first raises the pointer and then writes at the new location. A pop reads at the current location and then lowers the pointer. The block drives a synchronous single-port RAM: the address, write data and write enable are presented in a cycle, and the read data returns on the following cycle.

Beyond single bytes, the block handles subroutine linkage. A call request carries the 16-bit return address, which is the address of the instruction after the call. The block writes the low byte and then the high byte on two consecutive cycles. A return request reads the two bytes back in the opposite order and presents the restored 16-bit PC. During the second cycle of either two-byte operation, `busy` is high and new requests are ignored. The core can also overwrite the stack pointer, because it is visible as an ordinary special register. PC generation and instruction decode belong to the core.

Top module: `stack_unit`

## Requirements
- R1: After reset, `sp` is 07H, and `busy`, `pop_valid`, `pc_valid` and `ram_we` are all 0 while no request is present.
- R2: A push accepted in cycle T drives `ram_we`=1, `ram_addr`=`sp`+1 and `ram_wdata`=`push_data` in cycle T. From cycle T+1, `sp` has risen by 1.
- R3: A pop accepted in cycle T drives `ram_addr`=`sp` with `ram_we`=0 in cycle T. In cycle T+1, `pop_valid`=1 and `pop_data` holds the byte stored at that address, and `sp` has fallen by 1.
- R4: A call accepted in cycle T writes `ret_addr[7:0]` at `sp`+1 in cycle T. It writes `ret_addr[15:8]` at `sp`+2 in cycle T+1, with `busy`=1. `sp` ends 2 higher. For example, with `sp`=3AH and return address 0207H, 07H goes to 3BH, 02H goes to 3CH, and `sp` becomes 3CH.
- R5: A return accepted in cycle T reads at `sp` in cycle T and at `sp`-1 in cycle T+1, with `busy`=1. In cycle T+2, `pc_valid`=1 and `pc_out` = {byte at old `sp`, byte at old `sp`-1}. `sp` ends 2 lower, so a return restores the PC saved by the matching call.
- R6: When several requests are raised in the same idle cycle, exactly one is served, in the priority order call, return, push, pop. The others have no effect.
- R7: While `busy` is 1, push, pop, call, return and pointer-write requests are ignored. The in-progress operation is completed unchanged.
- R8: The pointer wraps modulo 256. A push at `sp`=FFH writes address 00H and leaves `sp`=00H. A pop at 00H leaves `sp`=FFH.
- R9: `sp_wr_en` loads `sp_wr_data` into `sp` on the next edge, but only in an idle cycle with no stack request. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push one byte |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Save a 16-bit return address |
| ret_req | input | 1 | Restore a 16-bit PC |
| push_data | input | 8 | Byte to push |
| ret_addr | input | 16 | Return address for a call |
| sp_wr_en | input | 1 | Write the stack pointer |
| sp_wr_data | input | 8 | New stack pointer value |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, one cycle after address |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Second cycle of a call or return |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | `pop_data` is valid |
| pc_out | output | 16 | Restored PC |
| pc_valid | output | 1 | `pc_out` is valid |

## Verification
Two kinds of collision can occur in the same cycle: two requests raised together, and a request arriving during the busy cycle of a call or return. Directed cases raise push with pop, call with every other request, and return with push and pop. They also hold a push or pop high through the busy cycle. Each case is judged by the RAM write pattern, the final pointer, and the absence of a stray `pop_valid`. A random mix of operations against a shadow memory then confirms that no stray write or pointer step crept in.

// File: rtl/stack_pkg.sv
package stack_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CALL,
        OP_RET,
        OP_PUSH,
        OP_POP
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALL_HI,
        ST_RET_LO
    } stk_st_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic push;
        logic pop;
    } stk_req_t;

    // Fixed priority: call, return, push, pop.
    function automatic stk_op_e pick_op(input stk_req_t r);
        if (r.call)      return OP_CALL;
        else if (r.ret)  return OP_RET;
        else if (r.push) return OP_PUSH;
        else if (r.pop)  return OP_POP;
        else             return OP_NONE;
    endfunction

endpackage

// File: rtl/stack_arbiter.sv
module stack_arbiter
    import stack_pkg::*;
(
    input  stk_req_t req,
    input  logic     busy,
    output stk_op_e  op
);
    always_comb begin
        op = busy ? OP_NONE : pick_op(req);
    end
endmodule

// File: rtl/stack_sp_reg.sv
module stack_sp_reg #(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp_q
);
    always_ff @(posedge clk) begin
        if (rst)       sp_q <= SP_RESET;
        else if (inc)  sp_q <= sp_q + AW'(1);
        else if (dec)  sp_q <= sp_q - AW'(1);
        else if (load) sp_q <= load_val;
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    localparam int unsigned PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op,
    input  logic [AW-1:0] sp,
    input  logic [DW-1:0] push_data,
    input  logic [PW-1:0] ret_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic          sp_inc,
    output logic          sp_dec,
    output logic          busy,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic [PW-1:0] pc_out,
    output logic          pc_valid
);
    stk_st_e       state_q, state_d;
    logic [DW-1:0] hi_save_q;
    logic [DW-1:0] pc_hi_q;
    logic          pop_v_q, pc_v_q;
    logic [AW-1:0] sp_up;

    assign sp_up = sp + AW'(1);
    assign busy  = (state_q != ST_IDLE);

    always_comb begin
        ram_addr  = sp;
        ram_wdata = '0;
        ram_we    = 1'b0;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        state_d   = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                unique case (op)
                    OP_CALL: begin
                        ram_addr  = sp_up;
                        ram_wdata = ret_addr[DW-1:0];
                        ram_we    = 1'b1;
                        sp_inc    = 1'b1;
                        state_d   = ST_CALL_HI;
                    end
                    OP_RET: begin
                        sp_dec  = 1'b1;
                        state_d = ST_RET_LO;
                    end
                    OP_PUSH: begin
                        ram_addr  = sp_up;
                        ram_wdata = push_data;
                        ram_we    = 1'b1;
                        sp_inc    = 1'b1;
                    end
                    OP_POP: begin
                        sp_dec = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_CALL_HI: begin
                ram_addr  = sp_up;
                ram_wdata = hi_save_q;
                ram_we    = 1'b1;
                sp_inc    = 1'b1;
            end
            ST_RET_LO: begin
                sp_dec = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hi_save_q <= '0;
            pc_hi_q   <= '0;
            pop_v_q   <= 1'b0;
            pc_v_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pop_v_q <= (state_q == ST_IDLE) && (op == OP_POP);
            pc_v_q  <= (state_q == ST_RET_LO);
            if ((state_q == ST_IDLE) && (op == OP_CALL))
                hi_save_q <= ret_addr[PW-1:DW];
            if (state_q == ST_RET_LO)
                pc_hi_q <= ram_rdata;
        end
    end

    assign pop_valid = pop_v_q;
    assign pop_data  = ram_rdata;
    assign pc_valid  = pc_v_q;
    assign pc_out    = {pc_hi_q, ram_rdata};
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stack_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07,
    localparam int unsigned PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [DW-1:0] push_data,
    input  logic [PW-1:0] ret_addr,
    input  logic          sp_wr_en,
    input  logic [AW-1:0] sp_wr_data,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] sp,
    output logic          busy,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic [PW-1:0] pc_out,
    output logic          pc_valid
);
    stk_req_t req;
    stk_op_e  op;
    logic     sp_inc, sp_dec, sp_load;

    assign req = '{call: call_req, ret: ret_req, push: push_req, pop: pop_req};

    stack_arbiter u_arb (
        .req  (req),
        .busy (busy),
        .op   (op)
    );

    // R9: pointer write only when idle and no stack request was taken
    assign sp_load = sp_wr_en && !busy && (op == OP_NONE);

    stack_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .load     (sp_load),
        .load_val (sp_wr_data),
        .sp_q     (sp)
    );

    stack_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .sp        (sp),
        .push_data (push_data),
        .ret_addr  (ret_addr),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .busy      (busy),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .pc_out    (pc_out),
        .pc_valid  (pc_valid)
    );
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    localparam int unsigned PW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic          push_req,
    input logic          pop_req,
    input logic          call_req,
    input logic          ret_req,
    input logic          sp_wr_en,
    input logic [AW-1:0] sp_wr_data,
    input logic [AW-1:0] ram_addr,
    input logic          ram_we,
    input logic [AW-1:0] sp,
    input logic          busy,
    input logic          pop_valid,
    input logic          pc_valid
);
    logic any_req;
    assign any_req = push_req || pop_req || call_req || ret_req;

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && !call_req && !ret_req) |=> (sp == $past(sp) + AW'(1))); // R2

    AST_WRITE_ABOVE_SP: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr == sp + AW'(1))); // R2

    AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
        (!busy && pop_req && !push_req && !call_req && !ret_req) |=> pop_valid); // R3

    AST_CALL_SECOND_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!busy && call_req) |=> (busy && ram_we)); // R4

    AST_RET_PC_VALID: assert property (@(posedge clk) disable iff (rst)
        (!busy && ret_req && !call_req) |=> ##1 pc_valid); // R5

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R7

    AST_SP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy && sp_wr_en && !any_req) |=> (sp == $past(sp_wr_data))); // R9
endmodule

bind stack_unit stack_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .sp_wr_en   (sp_wr_en),
    .sp_wr_data (sp_wr_data),
    .ram_addr   (ram_addr),
    .ram_we     (ram_we),
    .sp         (sp),
    .busy       (busy),
    .pop_valid  (pop_valid),
    .pc_valid   (pc_valid)
);

// File: tb/stack_unit_test.sv
module stack_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
    logic [7:0]  push_data = 0;
    logic [15:0] ret_addr = 0;
    logic        sp_wr_en = 0;
    logic [7:0]  sp_wr_data = 0;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata, sp, pop_data;
    logic        ram_we, busy, pop_valid, pc_valid;
    logic [15:0] pc_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] ram [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ref_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side synchronous RAM, read-first
    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        ram_rdata <= ram[ram_addr];
    end

    stack_unit uut (
        .clk(clk), .rst(rst),
        .push_req(push_req), .pop_req(pop_req), .call_req(call_req), .ret_req(ret_req),
        .push_data(push_data), .ret_addr(ret_addr),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .sp(sp), .busy(busy), .pop_data(pop_data), .pop_valid(pop_valid),
        .pc_out(pc_out), .pc_valid(pc_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pc(input logic [7:0] s);
        return {ref_mem[s], ref_mem[8'(s - 8'd1)]};
    endfunction

    task automatic clear_in();
        push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; sp_wr_en = 0;
    endtask

    // All tasks start and end in the low phase, just after a falling edge.
    task automatic do_load(input logic [7:0] v);
        sp_wr_en = 1; sp_wr_data = v;
        @(negedge clk); clear_in(); ref_sp = v; #1;
        chk("R9 load", sp, v);
    endtask

    task automatic do_push(input logic [7:0] d, input bit extra);
        push_req = 1; push_data = d;
        if (extra) begin pop_req = 1; sp_wr_en = 1; sp_wr_data = 8'h5A; end
        #1;
        chk("R2 we", ram_we, 1);
        chk("R2 addr", ram_addr, 8'(ref_sp + 8'd1));
        chk("R2 wdata", ram_wdata, d);
        @(negedge clk); clear_in();
        ref_sp = 8'(ref_sp + 8'd1); ref_mem[ref_sp] = d; #1;
        chk("R2 sp", sp, ref_sp);
        if (extra) chk("R6 pop ignored", pop_valid, 0);
    endtask

    task automatic do_pop();
        logic [7:0] e;
        pop_req = 1; #1;
        chk("R3 addr", ram_addr, ref_sp);
        chk("R3 no write", ram_we, 0);
        @(negedge clk); clear_in();
        e = ref_mem[ref_sp]; ref_sp = 8'(ref_sp - 8'd1); #1;
        chk("R3 valid", pop_valid, 1);
        chk("R3 data", pop_data, e);
        chk("R3 sp", sp, ref_sp);
    endtask

    task automatic do_call(input logic [15:0] a, input bit extra);
        call_req = 1; ret_addr = a;
        if (extra) begin push_req = 1; pop_req = 1; ret_req = 1; push_data = 8'hEE; end
        #1;
        chk("R4 lo we", ram_we, 1);
        chk("R4 lo addr", ram_addr, 8'(ref_sp + 8'd1));
        chk("R4 lo data", ram_wdata, a[7:0]);
        @(negedge clk); clear_in();
        if (extra) begin push_req = 1; pop_req = 1; ret_req = 1; sp_wr_en = 1; end
        #1;
        chk("R4 busy", busy, 1);
        chk("R4 hi addr", ram_addr, 8'(ref_sp + 8'd2));
        chk("R4 hi data", ram_wdata, a[15:8]);
        @(negedge clk); clear_in();
        ref_mem[8'(ref_sp + 8'd1)] = a[7:0];
        ref_mem[8'(ref_sp + 8'd2)] = a[15:8];
        ref_sp = 8'(ref_sp + 8'd2); #1;
        chk("R4 sp", sp, ref_sp);
        chk("R7 busy done", busy, 0);
        if (extra) chk("R7 pop ignored when busy", pop_valid, 0);
    endtask

    task automatic do_ret(input bit extra);
        logic [15:0] e;
        ret_req = 1;
        if (extra) begin push_req = 1; pop_req = 1; push_data = 8'hCC; end
        #1;
        chk("R5 addr hi", ram_addr, ref_sp);
        chk("R6 no write on ret", ram_we, 0);
        @(negedge clk); clear_in();
        if (extra) begin push_req = 1; call_req = 1; end
        #1;
        chk("R5 busy", busy, 1);
        chk("R5 addr lo", ram_addr, 8'(ref_sp - 8'd1));
        chk("R7 no write when busy", ram_we, 0);
        @(negedge clk); clear_in();
        e = exp_pc(ref_sp); ref_sp = 8'(ref_sp - 8'd2); #1;
        chk("R5 pc_valid", pc_valid, 1);
        chk("R5 pc_out", pc_out, e);
        chk("R5 sp", sp, ref_sp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; ref_mem[i] = 8'h00; end
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        ref_sp = 8'h07;
        chk("R1 sp", sp, 8'h07);
        chk("R1 busy", busy, 0);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 pc_valid", pc_valid, 0);
        chk("R1 we", ram_we, 0);

        // Two pushes from the reset pointer
        do_push(8'h55, 0);
        do_push(8'h4A, 0);
        chk("R2 ram 08", ram[8], 8'h55);
        chk("R2 ram 09", ram[9], 8'h4A);
        chk("R2 sp 09", sp, 8'h09);
        do_pop();
        do_pop();

        // Call from 3AH with return address 0207H
        do_load(8'h3A);
        do_call(16'h0207, 0);
        chk("R4 ram 3B", ram[8'h3B], 8'h07);
        chk("R4 ram 3C", ram[8'h3C], 8'h02);
        do_ret(0);

        // Same-cycle collisions and requests during busy
        do_push(8'h91, 1);
        do_call(16'hBEEF, 1);
        do_ret(1);
        do_pop();

        // Wrap at the top and bottom of the address space
        do_load(8'hFF);
        do_push(8'h3C, 0);
        chk("R8 sp wrap up", sp, 8'h00);
        chk("R8 ram 00", ram[0], 8'h3C);
        do_pop();
        chk("R8 sp wrap down", sp, 8'hFF);
        do_call(16'h1234, 0);
        do_ret(0);

        // Random mix
        do_load(8'h40);
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            k = $urandom_range(0, 5);
            case (k)
                0, 1: do_push(8'($urandom), 1'($urandom));
                2:    do_pop();
                3:    do_call(16'($urandom), 1'($urandom));
                4:    do_ret(1'($urandom));
                default: do_load(8'($urandom));
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule